// File: doc/BRIEF.md
# Lazy Coherence Home Directory

This block sits at the home node of a group of cache blocks and keeps their global coherence state for a multiple-writer, release-consistent memory system. Nodes send it read requests, write requests and drop notices (a drop covers both an invalidation at an acquire and a cache eviction). For each block it keeps a presence vector, a writer vector and a notified vector, together with a sharer count and a writer count. From these it decides the block's new state and what it must send back.

A read is never forwarded. After a fixed memory latency the home replies with data and the new state. A write that makes a block Weak triggers weak-state notices to every sharer that has not yet been told. The home then collects their acknowledgements itself and releases all waiting writers of that block with one final acknowledgement. While a block is collecting, further writes to it join the waiting set. Reads and drops to it are held at the request port until the collection ends.

Top module: `lzd_home_dir`

## Requirements
- R1: After reset every block is Uncached, no output is valid, and `req_ready` is high.
- R2: Block state codes are Uncached=0, Shared=1, Dirty=2, Weak=3. Dirty means exactly one sharer, and that sharer writes. Weak means two or more sharers with at least one writer. Shared means at least one sharer and no writer.
- R3: The sharer count and the writer count of every block always equal the number of set bits in its presence vector and its writer vector, and every writer is also present.
- R4: A read (`req_op`=0) is never forwarded. It gets one response of type data (`rsp_type`=0) to the requester, carrying the request tag and the block's new state. A read of a Weak block sends no notice.
- R5: A read by another node of a Dirty block moves the block to Weak and sends a notice (`ntf_mask`) to the writer.
- R6: A write (`req_op`=1) to a block that is Uncached, or that is cached only by the requester, gets an immediate write-ack (`rsp_type`=1) with state Dirty.
- R7: A write that makes the block Weak while other sharers are not yet notified replies wait (`rsp_type`=2) with state Weak. It sends one notice whose mask holds exactly those sharers.
- R8: A write to a block that is collecting also replies wait and joins the waiting set. In the cycle after the last outstanding notice ack arrives, one final ack (`fin_valid`) names every waiting writer in `fin_mask`.
- R9: While a block is collecting, reads and drops to it are held off (`req_ready` low). They are accepted once the collection ends.
- R10: A notice ack from a node that owes none for that block has no effect.
- R11: A drop (`req_op`=2 or 3) gets no response and removes the node from the records. With no sharers left the block becomes Uncached. With sharers but no writers it becomes Shared. With a single sharer that writes it becomes Dirty. Leaving Weak clears the notified marks.
- R12: A write to a Weak block whose sharers are all notified, with no collection in progress, gets a write-ack with state Weak and sends no notice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_node | input | NID_W | Requesting node |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 drop |
| req_blk | input | BID_W | Target block |
| req_tag | input | TAG_W | Tag echoed in the response |
| ack_valid | input | 1 | Notice ack present |
| ack_node | input | NID_W | Node sending the ack |
| ack_blk | input | BID_W | Block the ack refers to |
| rsp_valid | output | 1 | Response pulse |
| rsp_node | output | NID_W | Destination node |
| rsp_type | output | 2 | 0 data, 1 write-ack, 2 wait |
| rsp_state | output | 2 | New block state |
| rsp_blk | output | BID_W | Block |
| rsp_tag | output | TAG_W | Tag of the request |
| ntf_valid | output | 1 | Weak-state notice pulse |
| ntf_blk | output | BID_W | Block of the notice |
| ntf_mask | output | NODES | Nodes receiving the notice |
| fin_valid | output | 1 | Final write-ack pulse |
| fin_blk | output | BID_W | Block whose collection ended |
| fin_mask | output | NODES | Writers released |

## Verification
The hardest situation to reach is a block in the middle of a collection with a second writer already joined, a read held at the port, and stray acks arriving. The stimulus builds two Shared readers, lets one of them write so that the other owes an ack, and then has the second reader write as well. It then sends acks from a node and a block that owe nothing, and only after that the real ack. The held read must enter after the final ack, which must name both writers. The drop paths back to Shared, Dirty and Uncached are then reached by removing sharers one by one and probing each result with a write or a read whose reply shows the state.

// File: rtl/lzd_pkg.sv
package lzd_pkg;

   typedef enum logic [1:0] {
      ST_UNC  = 2'd0,
      ST_SHR  = 2'd1,
      ST_DRT  = 2'd2,
      ST_WEAK = 2'd3
   } bstate_e;

   typedef enum logic [1:0] {
      RK_DATA = 2'd0,
      RK_WACK = 2'd1,
      RK_WAIT = 2'd2
   } rkind_e;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_MEM   = 2'd1,
      FS_APPLY = 2'd2
   } fsm_e;

   localparam logic [1:0] OP_RD = 2'd0;
   localparam logic [1:0] OP_WR = 2'd1;

endpackage

// File: rtl/lzd_lat_pipe.sv
module lzd_lat_pipe #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);

   generate
      if (LAT == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= start_i;
         end
         assign done_o = stage_q;
      end else begin : g_shift
         logic [LAT-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[LAT-2:0], start_i};
         end
         assign done_o = sr_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/lzd_xition.sv
module lzd_xition
   import lzd_pkg::*;
#(
   parameter int NODES = 8,
   parameter int NID_W = 3,
   parameter int CNT_W = 4
) (
   input  bstate_e            st_i,
   input  logic [NODES-1:0]   pres_i,
   input  logic [NODES-1:0]   wr_i,
   input  logic [NODES-1:0]   ntf_i,
   input  logic [CNT_W-1:0]   csh_i,
   input  logic [CNT_W-1:0]   cwr_i,
   input  logic               busy_i,
   input  logic [1:0]         op_i,
   input  logic [NID_W-1:0]   node_i,
   output bstate_e            st_o,
   output logic [NODES-1:0]   pres_o,
   output logic [NODES-1:0]   wr_o,
   output logic [NODES-1:0]   ntf_o,
   output logic [CNT_W-1:0]   csh_o,
   output logic [CNT_W-1:0]   cwr_o,
   output logic               has_rsp_o,
   output rkind_e             kind_o,
   output logic [NODES-1:0]   tgt_o,
   output logic               join_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [NODES-1:0] rbit;
   logic             in_p;
   logic             in_w;
   logic [CNT_W-1:0] dp;
   logic [CNT_W-1:0] dw;

   always_comb begin
      rbit = {{(NODES-1){1'b0}}, 1'b1} << node_i;
      in_p = pres_i[node_i];
      in_w = wr_i[node_i];
      st_o      = st_i;
      pres_o    = pres_i;
      wr_o      = wr_i;
      ntf_o     = ntf_i;
      csh_o     = csh_i;
      cwr_o     = cwr_i;
      has_rsp_o = 1'b0;
      kind_o    = RK_DATA;
      tgt_o     = '0;
      join_o    = 1'b0;
      if (op_i == OP_RD) begin
         dp        = {{(CNT_W-1){1'b0}}, ~in_p};
         dw        = '0;
         pres_o    = pres_i | rbit;
         csh_o     = csh_i + dp;
         has_rsp_o = 1'b1;
         kind_o    = RK_DATA;
         if (st_i == ST_DRT && !in_p) begin
            st_o  = ST_WEAK;
            tgt_o = wr_i & ~ntf_i;
            ntf_o = ntf_i | tgt_o | rbit;
         end else if (st_i == ST_UNC) begin
            st_o = ST_SHR;
         end else if (st_i == ST_WEAK) begin
            ntf_o = ntf_i | rbit;
         end
      end else if (op_i == OP_WR) begin
         dp        = {{(CNT_W-1){1'b0}}, ~in_p};
         dw        = {{(CNT_W-1){1'b0}}, ~in_w};
         pres_o    = pres_i | rbit;
         wr_o      = wr_i | rbit;
         csh_o     = csh_i + dp;
         cwr_o     = cwr_i + dw;
         has_rsp_o = 1'b1;
         if (csh_o == ONE) begin
            st_o   = ST_DRT;
            ntf_o  = '0;
            kind_o = RK_WACK;
         end else begin
            st_o  = ST_WEAK;
            tgt_o = pres_o & ~ntf_i & ~rbit;
            ntf_o = ntf_i | pres_o;
            if ((|tgt_o) || busy_i) begin
               kind_o = RK_WAIT;
               join_o = 1'b1;
            end else begin
               kind_o = RK_WACK;
            end
         end
      end else begin
         dp     = {{(CNT_W-1){1'b0}}, in_p};
         dw     = {{(CNT_W-1){1'b0}}, in_w};
         pres_o = pres_i & ~rbit;
         wr_o   = wr_i & ~rbit;
         csh_o  = csh_i - dp;
         cwr_o  = cwr_i - dw;
         if (csh_o == '0)       st_o = ST_UNC;
         else if (cwr_o == '0)  st_o = ST_SHR;
         else if (csh_o == ONE) st_o = ST_DRT;
         else                   st_o = st_i;
         ntf_o = (st_o == ST_WEAK) ? (ntf_i & ~rbit) : '0;
      end
   end

endmodule

// File: rtl/lzd_home_dir.sv
module lzd_home_dir
   import lzd_pkg::*;
#(
   parameter int NODES   = 8,
   parameter int BLOCKS  = 16,
   parameter int TAG_W   = 4,
   parameter int MEM_LAT = 3,
   localparam int NID_W  = $clog2(NODES),
   localparam int BID_W  = $clog2(BLOCKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [NID_W-1:0]   req_node,
   input  logic [1:0]         req_op,
   input  logic [BID_W-1:0]   req_blk,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic               ack_valid,
   input  logic [NID_W-1:0]   ack_node,
   input  logic [BID_W-1:0]   ack_blk,
   output logic               rsp_valid,
   output logic [NID_W-1:0]   rsp_node,
   output logic [1:0]         rsp_type,
   output logic [1:0]         rsp_state,
   output logic [BID_W-1:0]   rsp_blk,
   output logic [TAG_W-1:0]   rsp_tag,
   output logic               ntf_valid,
   output logic [BID_W-1:0]   ntf_blk,
   output logic [NODES-1:0]   ntf_mask,
   output logic               fin_valid,
   output logic [BID_W-1:0]   fin_blk,
   output logic [NODES-1:0]   fin_mask
);

   localparam int CNT_W = $clog2(NODES + 1);

   generate
      if (NODES < 2 || (NODES & (NODES - 1)) != 0) begin : g_bad_nodes
         $error("NODES must be a power of two, at least 2");
      end
      if (BLOCKS < 2 || (BLOCKS & (BLOCKS - 1)) != 0) begin : g_bad_blocks
         $error("BLOCKS must be a power of two, at least 2");
      end
      if (MEM_LAT < 1) begin : g_bad_lat
         $error("MEM_LAT must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
   endgenerate

   // directory storage
   bstate_e          st_q    [BLOCKS];
   logic [NODES-1:0] pres_q  [BLOCKS];
   logic [NODES-1:0] wr_q    [BLOCKS];
   logic [NODES-1:0] ntf_q   [BLOCKS];
   logic [CNT_W-1:0] csh_q   [BLOCKS];
   logic [CNT_W-1:0] cwr_q   [BLOCKS];
   logic [NODES-1:0] await_q [BLOCKS];
   logic [NODES-1:0] waitw_q [BLOCKS];
   logic [NODES-1:0] await_n [BLOCKS];
   logic [NODES-1:0] waitw_n [BLOCKS];
   logic [BLOCKS-1:0] done_v;

   // request sequencing
   fsm_e             fsm_q;
   logic [NID_W-1:0] cur_node;
   logic [1:0]       cur_op;
   logic [BID_W-1:0] cur_blk;
   logic [TAG_W-1:0] cur_tag;
   logic             accept;
   logic             apply;
   logic             mem_done;
   logic [NODES-1:0] cur_rbit;
   logic [NODES-1:0] ack_rbit;

   assign req_ready = (fsm_q == FS_IDLE) && ((req_op == OP_WR) || (waitw_q[req_blk] == '0));
   assign accept    = req_valid && req_ready;
   assign apply     = (fsm_q == FS_APPLY);
   assign cur_rbit  = {{(NODES-1){1'b0}}, 1'b1} << cur_node;
   assign ack_rbit  = {{(NODES-1){1'b0}}, 1'b1} << ack_node;

   lzd_lat_pipe #(.LAT(MEM_LAT)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept && (req_op == OP_RD)),
      .done_o  (mem_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q    <= FS_IDLE;
         cur_node <= '0;
         cur_op   <= '0;
         cur_blk  <= '0;
         cur_tag  <= '0;
      end else begin
         case (fsm_q)
            FS_IDLE: if (accept) begin
               cur_node <= req_node;
               cur_op   <= req_op;
               cur_blk  <= req_blk;
               cur_tag  <= req_tag;
               fsm_q    <= (req_op == OP_RD) ? FS_MEM : FS_APPLY;
            end
            FS_MEM:  if (mem_done) fsm_q <= FS_APPLY;
            default: fsm_q <= FS_IDLE;
         endcase
      end
   end

   // state transition for the addressed block
   bstate_e          x_st;
   logic [NODES-1:0] x_pres, x_wr, x_ntf, x_tgt;
   logic [CNT_W-1:0] x_csh, x_cwr;
   logic             x_has_rsp, x_join;
   rkind_e           x_kind;

   lzd_xition #(.NODES(NODES), .NID_W(NID_W), .CNT_W(CNT_W)) u_xition (
      .st_i      (st_q[cur_blk]),
      .pres_i    (pres_q[cur_blk]),
      .wr_i      (wr_q[cur_blk]),
      .ntf_i     (ntf_q[cur_blk]),
      .csh_i     (csh_q[cur_blk]),
      .cwr_i     (cwr_q[cur_blk]),
      .busy_i    (waitw_q[cur_blk] != '0),
      .op_i      (cur_op),
      .node_i    (cur_node),
      .st_o      (x_st),
      .pres_o    (x_pres),
      .wr_o      (x_wr),
      .ntf_o     (x_ntf),
      .csh_o     (x_csh),
      .cwr_o     (x_cwr),
      .has_rsp_o (x_has_rsp),
      .kind_o    (x_kind),
      .tgt_o     (x_tgt),
      .join_o    (x_join)
   );

   // per-block entry and ack collection
   generate
      for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
         localparam logic [BID_W-1:0] BIDX = BID_W'(b);
         logic sel_b;
         logic ack_b;
         assign sel_b = apply && (cur_blk == BIDX);
         assign ack_b = ack_valid && (ack_blk == BIDX);
         assign await_n[b] = (await_q[b] & ~(ack_b ? ack_rbit : '0))
                           | ((sel_b && cur_op == OP_WR) ? x_tgt : '0);
         assign waitw_n[b] = waitw_q[b] | ((sel_b && x_join) ? cur_rbit : '0);
         assign done_v[b]  = (waitw_n[b] != '0) && (await_n[b] == '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q[b]    <= ST_UNC;
               pres_q[b]  <= '0;
               wr_q[b]    <= '0;
               ntf_q[b]   <= '0;
               csh_q[b]   <= '0;
               cwr_q[b]   <= '0;
               await_q[b] <= '0;
               waitw_q[b] <= '0;
            end else begin
               if (sel_b) begin
                  st_q[b]   <= x_st;
                  pres_q[b] <= x_pres;
                  wr_q[b]   <= x_wr;
                  ntf_q[b]  <= x_ntf;
                  csh_q[b]  <= x_csh;
                  cwr_q[b]  <= x_cwr;
               end
               await_q[b] <= await_n[b];
               waitw_q[b] <= done_v[b] ? '0 : waitw_n[b];
            end
         end

         AST_CNT_SH: assert property (@(posedge clk) disable iff (!rst_n) int'(csh_q[b]) == $countones(pres_q[b])); // R3
         AST_CNT_WR: assert property (@(posedge clk) disable iff (!rst_n) int'(cwr_q[b]) == $countones(wr_q[b])); // R3
         AST_WR_IN_PRES: assert property (@(posedge clk) disable iff (!rst_n) (wr_q[b] & ~pres_q[b]) == '0); // R3
         AST_DRT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (st_q[b] == ST_DRT) |-> (csh_q[b] == CNT_W'(1) && cwr_q[b] == CNT_W'(1))); // R2
         AST_WEAK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (st_q[b] == ST_WEAK) |-> (csh_q[b] >= CNT_W'(2) && cwr_q[b] >= CNT_W'(1))); // R2
         AST_SHR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (st_q[b] == ST_SHR) |-> (cwr_q[b] == '0 && csh_q[b] >= CNT_W'(1))); // R2
         AST_UNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (st_q[b] == ST_UNC) |-> (pres_q[b] == '0)); // R11
         AST_WAIT_OWED: assert property (@(posedge clk) disable iff (!rst_n) (waitw_q[b] != '0) |-> (await_q[b] != '0)); // R8
      end
   endgenerate

   // final ack selection
   logic [NODES-1:0] fin_mask_n;
   logic [BID_W-1:0] fin_blk_n;
   always_comb begin
      fin_mask_n = '0;
      fin_blk_n  = '0;
      for (int b = 0; b < BLOCKS; b++) begin
         if (done_v[b]) begin
            fin_mask_n = waitw_n[b];
            fin_blk_n  = BID_W'(b);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_node  <= '0;
         rsp_type  <= '0;
         rsp_state <= '0;
         rsp_blk   <= '0;
         rsp_tag   <= '0;
         ntf_valid <= 1'b0;
         ntf_blk   <= '0;
         ntf_mask  <= '0;
         fin_valid <= 1'b0;
         fin_blk   <= '0;
         fin_mask  <= '0;
      end else begin
         rsp_valid <= apply && x_has_rsp;
         ntf_valid <= apply && (x_tgt != '0);
         fin_valid <= (done_v != '0);
         if (apply) begin
            rsp_node  <= cur_node;
            rsp_type  <= x_kind;
            rsp_state <= x_st;
            rsp_blk   <= cur_blk;
            rsp_tag   <= cur_tag;
            ntf_blk   <= cur_blk;
            ntf_mask  <= x_tgt;
         end
         if (done_v != '0) begin
            fin_blk  <= fin_blk_n;
            fin_mask <= fin_mask_n;
         end
      end
   end

   AST_RSP_FROM_APPLY: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(fsm_q == FS_APPLY)); // R4
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (apply && cur_op != OP_WR) |-> (waitw_q[cur_blk] == '0)); // R9
   AST_FIN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) fin_valid |-> $past(ack_valid)); // R8
   AST_ONE_FIN: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done_v)); // R8

endmodule

// File: tb/sim_lzd_home_dir.sv
module sim_lzd_home_dir;

   localparam int CLK_PERIOD = 10;
   localparam int NODES   = 8;
   localparam int BLOCKS  = 16;
   localparam int TAG_W   = 4;
   localparam int MEM_LAT = 3;
   localparam int NID_W   = 3;
   localparam int BID_W   = 4;

   localparam int K_RSP = 0, K_NTF = 1, K_FIN = 2;
   localparam int T_DATA = 0, T_WACK = 1, T_WAIT = 2;
   localparam int S_UNC = 0, S_SHR = 1, S_DRT = 2, S_WEAK = 3;
   localparam int O_RD = 0, O_WR = 1, O_DROP = 2;

   typedef struct {
      int    kind;
      int    node;
      int    typ;
      int    st;
      int    tag;
      int    blk;
      int    mask;
      string rq;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [NID_W-1:0] req_node = '0;
   logic [1:0]       req_op = '0;
   logic [BID_W-1:0] req_blk = '0;
   logic [TAG_W-1:0] req_tag = '0;
   logic ack_valid = 1'b0;
   logic [NID_W-1:0] ack_node = '0;
   logic [BID_W-1:0] ack_blk = '0;
   logic rsp_valid;
   logic [NID_W-1:0] rsp_node;
   logic [1:0] rsp_type, rsp_state;
   logic [BID_W-1:0] rsp_blk;
   logic [TAG_W-1:0] rsp_tag;
   logic ntf_valid;
   logic [BID_W-1:0] ntf_blk;
   logic [NODES-1:0] ntf_mask;
   logic fin_valid;
   logic [BID_W-1:0] fin_blk;
   logic [NODES-1:0] fin_mask;

   int n_run = 0;
   int n_fail = 0;
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lzd_home_dir #(.NODES(NODES), .BLOCKS(BLOCKS), .TAG_W(TAG_W), .MEM_LAT(MEM_LAT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
      .req_op(req_op), .req_blk(req_blk), .req_tag(req_tag),
      .ack_valid(ack_valid), .ack_node(ack_node), .ack_blk(ack_blk),
      .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_type(rsp_type),
      .rsp_state(rsp_state), .rsp_blk(rsp_blk), .rsp_tag(rsp_tag),
      .ntf_valid(ntf_valid), .ntf_blk(ntf_blk), .ntf_mask(ntf_mask),
      .fin_valid(fin_valid), .fin_blk(fin_blk), .fin_mask(fin_mask)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic push_rsp(input int node, input int typ, input int st, input int tag, input int blk, input string rq);
      item_t e;
      e.kind = K_RSP; e.node = node; e.typ = typ; e.st = st; e.tag = tag; e.blk = blk; e.mask = 0; e.rq = rq;
      exp_q.push_back(e);
   endtask

   task automatic push_vec(input int kind, input int blk, input int mask, input string rq);
      item_t e;
      e.kind = kind; e.node = 0; e.typ = 0; e.st = 0; e.tag = 0; e.blk = blk; e.mask = mask; e.rq = rq;
      exp_q.push_back(e);
   endtask

   task automatic take(input int kind, input int node, input int typ, input int st, input int tag, input int blk, input int mask);
      item_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4", "unexpected output kind", kind, -1);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind, e.rq, "output kind", kind, e.kind);
         if (e.kind == kind) begin
            chk(e.blk == blk, e.rq, "block", blk, e.blk);
            if (kind == K_RSP) begin
               chk(e.node == node, e.rq, "rsp node", node, e.node);
               chk(e.typ == typ, e.rq, "rsp type", typ, e.typ);
               chk(e.st == st, e.rq, "rsp state", st, e.st);
               chk(e.tag == tag, e.rq, "rsp tag", tag, e.tag);
            end else begin
               chk(e.mask == mask, e.rq, "node mask", mask, e.mask);
            end
         end
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) take(K_RSP, int'(rsp_node), int'(rsp_type), int'(rsp_state), int'(rsp_tag), int'(rsp_blk), 0);
         if (ntf_valid) take(K_NTF, 0, 0, 0, 0, int'(ntf_blk), int'(ntf_mask));
         if (fin_valid) take(K_FIN, 0, 0, 0, 0, int'(fin_blk), int'(fin_mask));
      end
   end

   task automatic do_req(input int node, input int op, input int blk, input int tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_node  = NID_W'(node);
      req_op    = 2'(op);
      req_blk   = BID_W'(blk);
      req_tag   = TAG_W'(tag);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (MEM_LAT + 4) @(negedge clk);
   endtask

   task automatic do_ack(input int node, input int blk);
      @(negedge clk);
      ack_valid = 1'b1;
      ack_node  = NID_W'(node);
      ack_blk   = BID_W'(blk);
      @(negedge clk);
      ack_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs and ready after reset
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
      chk(ntf_valid == 1'b0, "R1", "ntf_valid", int'(ntf_valid), 0);
      chk(fin_valid == 1'b0, "R1", "fin_valid", int'(fin_valid), 0);
      chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);

      // block 0: Uncached -> Shared by read (R1, R4)
      push_rsp(1, T_DATA, S_SHR, 1, 0, "R1");
      do_req(1, O_RD, 0, 1);
      // only sharer writes: Dirty with immediate ack (R6)
      push_rsp(1, T_WACK, S_DRT, 2, 0, "R6");
      do_req(1, O_WR, 0, 2);
      // read by another node of Dirty: Weak plus notice to writer (R5)
      push_rsp(2, T_DATA, S_WEAK, 3, 0, "R5");
      push_vec(K_NTF, 0, 8'h02, "R5");
      do_req(2, O_RD, 0, 3);
      // read of Weak block: no notice (R4)
      push_rsp(3, T_DATA, S_WEAK, 4, 0, "R4");
      do_req(3, O_RD, 0, 4);
      // write to Weak with all notified: immediate ack (R12)
      push_rsp(2, T_WACK, S_WEAK, 5, 0, "R12");
      do_req(2, O_WR, 0, 5);
      // drops leave a single writer: Dirty, notified marks cleared (R11)
      do_req(2, O_DROP, 0, 0);
      do_req(3, 3, 0, 0);
      push_rsp(3, T_DATA, S_WEAK, 6, 0, "R11");
      push_vec(K_NTF, 0, 8'h02, "R11");
      do_req(3, O_RD, 0, 6);

      // block 1: two readers, then collecting writes
      push_rsp(4, T_DATA, S_SHR, 7, 1, "R4");
      do_req(4, O_RD, 1, 7);
      push_rsp(5, T_DATA, S_SHR, 8, 1, "R4");
      do_req(5, O_RD, 1, 8);
      push_rsp(4, T_WAIT, S_WEAK, 9, 1, "R7");
      push_vec(K_NTF, 1, 8'h20, "R7");
      do_req(4, O_WR, 1, 9);
      push_rsp(5, T_WAIT, S_WEAK, 10, 1, "R8");
      do_req(5, O_WR, 1, 10);
      // stray acks change nothing (R10)
      do_ack(7, 1);
      chk(fin_valid == 1'b0, "R10", "fin after stray ack", int'(fin_valid), 0);
      do_ack(5, 2);
      chk(fin_valid == 1'b0, "R10", "fin after wrong-block ack", int'(fin_valid), 0);
      // read held off during collection (R9)
      @(negedge clk);
      req_valid = 1'b1; req_node = 3'd6; req_op = 2'd0; req_blk = 4'd1; req_tag = 4'd11;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_ready == 1'b0, "R9", "req_ready while collecting", int'(req_ready), 0);
      end
      push_vec(K_FIN, 1, 8'h30, "R8");
      push_rsp(6, T_DATA, S_WEAK, 11, 1, "R9");
      ack_valid = 1'b1; ack_node = 3'd5; ack_blk = 4'd1;
      @(negedge clk);
      ack_valid = 1'b0;
      chk(req_ready == 1'b1, "R9", "req_ready after collection", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (MEM_LAT + 4) @(negedge clk);
      // writers drop: back to Shared (R11)
      do_req(4, O_DROP, 1, 0);
      do_req(5, O_DROP, 1, 0);
      push_rsp(7, T_WAIT, S_WEAK, 12, 1, "R11");
      push_vec(K_NTF, 1, 8'h40, "R7");
      do_req(7, O_WR, 1, 12);
      push_vec(K_FIN, 1, 8'h80, "R8");
      do_ack(6, 1);
      // all drop: Uncached, so a write gets Dirty at once (R11, R6)
      do_req(6, O_DROP, 1, 0);
      do_req(7, O_DROP, 1, 0);
      push_rsp(3, T_WACK, S_DRT, 13, 1, "R11");
      do_req(3, O_WR, 1, 13);
      // untouched block starts Uncached (R6)
      push_rsp(0, T_WACK, S_DRT, 14, 2, "R6");
      do_req(0, O_WR, 2, 14);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R4", "expected outputs left", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule